// File: doc/BRIEF.md
# Two-Button Sequence Combination Lock

This block is a Moore state machine that opens a lock when a four-digit code is keyed in on two push-buttons. One button enters the digit 0 and the other enters the digit 1. The single `unlock` output is high only while the four most recently accepted digits, oldest first, are 0, 1, 1, 0. The buttons are raw asynchronous levels that a person may hold for any number of clock cycles. Each button therefore passes through a flip-flop synchronizer before any logic looks at it. A press qualifier then turns each press into exactly one digit event and waits until both buttons are back low before it accepts another.

The code detector keeps the longest useful prefix of the code. On a wrong digit it falls back to a shorter prefix and does not always return to idle, so overlapping entries such as 0110110 open the lock twice. There are five detector states: ST_IDLE (no useful prefix), ST_0, ST_01, ST_011 and ST_0110. The transitions are listed below, with the digit that causes each one.

- ST_IDLE: digit 0 goes to ST_0; digit 1 stays in ST_IDLE.
- ST_0: digit 0 stays in ST_0; digit 1 goes to ST_01.
- ST_01: digit 0 goes to ST_0; digit 1 goes to ST_011.
- ST_011: digit 0 goes to ST_0110; digit 1 goes to ST_IDLE.
- ST_0110: digit 0 goes to ST_0; digit 1 goes to ST_01.

The qualifier has two states. QS_READY emits a digit when exactly one synchronized button is high, then moves to QS_HELD. If both buttons are high it moves to QS_HELD without emitting a digit. QS_HELD returns to QS_READY once both synchronized buttons read low.

Top module: `press_code_lock`

## Requirements
- R1: While `rst` is high at a rising clock edge, that edge sets `unlock` to 0 and the detector to ST_IDLE. A 0 pressed first after reset therefore leaves `unlock` at 0.
- R2: `unlock` is 1 exactly when the last four accepted digits were 0,1,1,0 (detector in ST_0110), and 0 in every other detector state.
- R3: In ST_IDLE a 1 keeps ST_IDLE and a 0 moves to ST_0. In ST_0 a 0 keeps ST_0 and a 1 moves to ST_01. In ST_01 a 0 falls back to ST_0 and a 1 moves to ST_011.
- R4: In ST_011 a 0 moves to ST_0110 and a 1 falls back to ST_IDLE. In ST_0110 a 0 moves to ST_0 and a 1 moves to ST_01, so overlapping codes are recognised.
- R5: A press held for any number of cycles is accepted as exactly one digit. No second digit is accepted until both buttons have read low.
- R6: If both buttons are seen high in the same cycle, no digit is accepted and the detector state is unchanged. Nothing is accepted again until both buttons read low, even if one of them is released first.
- R7: A second button pressed while the first is still held is ignored.
- R8: A button level first sampled high at rising edge k changes `unlock` at edge k+SYNC_STAGES. With the default of 2 stages this is the third edge.
- R9: `unlock` stays 1 while the detector is in ST_0110, including the whole time the final 0 is held. It drops at the next accepted digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key0_raw | input | 1 | Asynchronous level of the digit-0 button, high while pressed |
| key1_raw | input | 1 | Asynchronous level of the digit-1 button, high while pressed |
| unlock | output | 1 | High while the last four accepted digits are 0,1,1,0 |

## Verification
The bench builds the lock with the default SYNC_STAGES of 2. At that depth a press reaches `unlock` on the third rising edge, and the bench checks that exact edge as well as the two edges before it. With a short synchronizer, presses held for 3 to 40 cycles and release gaps of 4 cycles are enough to exercise every detector transition and the overlap restarts. The same setup covers both-button presses, a second button pressed during a hold and a reset in the middle of a code.

// File: rtl/plock_pkg.sv
`timescale 1ns/1ps
package plock_pkg;

    localparam int KEY_COUNT = 2;

    // Sequence detector: longest matched prefix of 0,1,1,0
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_0    = 3'd1,
        ST_01   = 3'd2,
        ST_011  = 3'd3,
        ST_0110 = 3'd4
    } code_state_e;

    // Press qualifier: accept one digit, then wait for full release
    typedef enum logic {
        QS_READY = 1'b0,
        QS_HELD  = 1'b1
    } qual_state_e;

endpackage

// File: rtl/key_sync.sv
`timescale 1ns/1ps
module key_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], raw_in[b]};
            end
        end

        assign sync_out[b] = chain[LAST];
    end

endmodule

// File: rtl/press_qual.sv
`timescale 1ns/1ps
module press_qual
    import plock_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [KEY_COUNT-1:0] lvl,
    output logic                 dig_vld,
    output logic                 dig_val
);

    qual_state_e q_st, q_nxt;
    logic        any_high;
    logic        one_high;

    assign any_high = |lvl;
    assign one_high = (lvl == 2'b01) || (lvl == 2'b10);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            q_st <= QS_READY;
        end else begin
            q_st <= q_nxt;
        end
    end

    // Next state
    always_comb begin
        q_nxt = q_st;
        unique case (q_st)
            QS_READY: if (any_high) q_nxt = QS_HELD;
            QS_HELD:  if (!any_high) q_nxt = QS_READY;
            default:  q_nxt = QS_READY;
        endcase
    end

    // Outputs: a digit only on a lone press seen in READY
    always_comb begin
        dig_vld = 1'b0;
        dig_val = 1'b0;
        unique case (q_st)
            QS_READY: begin
                dig_vld = one_high;
                dig_val = lvl[1];
            end
            QS_HELD: begin
                dig_vld = 1'b0;
                dig_val = 1'b0;
            end
            default: begin
                dig_vld = 1'b0;
                dig_val = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/code_fsm.sv
`timescale 1ns/1ps
module code_fsm
    import plock_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        dig_vld,
    input  logic        dig_val,
    output code_state_e st_o,
    output logic        unlock_o
);

    code_state_e st, nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
        end else begin
            st <= nxt;
        end
    end

    // Next state, with fall-back to the longest remaining prefix
    always_comb begin
        nxt = st;
        if (dig_vld) begin
            unique case (st)
                ST_IDLE: nxt = dig_val ? ST_IDLE : ST_0;
                ST_0:    nxt = dig_val ? ST_01   : ST_0;
                ST_01:   nxt = dig_val ? ST_011  : ST_0;
                ST_011:  nxt = dig_val ? ST_IDLE : ST_0110;
                ST_0110: nxt = dig_val ? ST_01   : ST_0;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // Moore output, registered from the next state
    always_ff @(posedge clk) begin
        if (rst) begin
            unlock_o <= 1'b0;
        end else begin
            unlock_o <= (nxt == ST_0110);
        end
    end

    assign st_o = st;

endmodule

// File: rtl/press_code_lock.sv
`timescale 1ns/1ps
module press_code_lock #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic key0_raw,
    input  logic key1_raw,
    output logic unlock
);

    import plock_pkg::*;

    logic [KEY_COUNT-1:0] sync_lvl;
    logic                 dig_vld;
    logic                 dig_val;
    code_state_e          code_st;

    key_sync #(
        .WIDTH  (KEY_COUNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .raw_in   ({key1_raw, key0_raw}),
        .sync_out (sync_lvl)
    );

    press_qual u_qual (
        .clk     (clk),
        .rst     (rst),
        .lvl     (sync_lvl),
        .dig_vld (dig_vld),
        .dig_val (dig_val)
    );

    code_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .dig_vld  (dig_vld),
        .dig_val  (dig_val),
        .st_o     (code_st),
        .unlock_o (unlock)
    );

endmodule

// File: rtl/press_code_lock_chk.sv
`timescale 1ns/1ps
module press_code_lock_chk
    import plock_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        unlock,
    input logic [1:0]  sync_lvl,
    input logic        dig_vld,
    input logic        dig_val,
    input code_state_e code_st
);

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1
    always @(negedge clk) begin
        if (rst_d == 1'b1) begin
            reset_clears_chk: assert (!unlock && code_st == ST_IDLE);
        end
    end

    // R2
    unlock_rise_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(unlock) |-> ($past(dig_vld) && !$past(dig_val)));

    // R2
    unlock_matches_state_chk: assert property (@(posedge clk) disable iff (rst)
        unlock == (code_st == ST_0110));

    // R3
    fallback_from_01_chk: assert property (@(posedge clk) disable iff (rst)
        (code_st == ST_01 && dig_vld && !dig_val) |=> (code_st == ST_0));

    // R4
    restart_from_011_chk: assert property (@(posedge clk) disable iff (rst)
        (code_st == ST_011 && dig_vld && dig_val) |=> (code_st == ST_IDLE));

    // R5
    one_digit_per_press_chk: assert property (@(posedge clk) disable iff (rst)
        dig_vld |=> !dig_vld);

    // R6
    both_keys_no_digit_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_lvl == 2'b11) |-> !dig_vld);

    // R9
    unlock_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (unlock && !dig_vld) |=> unlock);

endmodule

bind press_code_lock press_code_lock_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .unlock   (unlock),
    .sync_lvl (sync_lvl),
    .dig_vld  (dig_vld),
    .dig_val  (dig_val),
    .code_st  (code_st)
);

// File: tb/sim_press_code_lock.sv
`timescale 1ns/1ps
module sim_press_code_lock;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic key0_raw = 1'b0;
    logic key1_raw = 1'b0;
    logic unlock;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    press_code_lock #(.SYNC_STAGES(2)) u0 (
        .clk      (clk),
        .rst      (rst),
        .key0_raw (key0_raw),
        .key1_raw (key1_raw),
        .unlock   (unlock)
    );

    // Vector: [5:4] key code (0 = key0, 1 = key1, 2 = both), [3] expected unlock, [2:0] tag
    localparam int NVEC = 20;
    localparam logic [5:0] VEC [NVEC] = '{
        {2'd0, 1'b0, 3'd3}, {2'd1, 1'b0, 3'd2}, {2'd1, 1'b0, 3'd2}, {2'd0, 1'b1, 3'd2},
        {2'd1, 1'b0, 3'd4}, {2'd1, 1'b0, 3'd2}, {2'd0, 1'b1, 3'd4}, {2'd2, 1'b1, 3'd6},
        {2'd0, 1'b0, 3'd4}, {2'd0, 1'b0, 3'd3}, {2'd1, 1'b0, 3'd2}, {2'd0, 1'b0, 3'd3},
        {2'd1, 1'b0, 3'd2}, {2'd1, 1'b0, 3'd2}, {2'd1, 1'b0, 3'd4}, {2'd1, 1'b0, 3'd3},
        {2'd0, 1'b0, 3'd2}, {2'd1, 1'b0, 3'd2}, {2'd1, 1'b0, 3'd2}, {2'd0, 1'b1, 3'd2}
    };

    function automatic string tag_name(input logic [2:0] t);
        case (t)
            3'd2:    return "R2";
            3'd3:    return "R3";
            3'd4:    return "R4";
            3'd6:    return "R6";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: unlock=%0b expected %0b", req, act, exp);
        end
    endtask

    task automatic press(input logic [1:0] code, input int hold);
        @(negedge clk);
        key0_raw = (code == 2'd0) || (code == 2'd2);
        key1_raw = (code == 2'd1) || (code == 2'd2);
        repeat (hold) @(negedge clk);
        key0_raw = 1'b0;
        key1_raw = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: unlock=%0b expected run to finish", unlock);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset value", unlock, 1'b0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // Table walk: one press per vector, then check unlock
        for (int i = 0; i < NVEC; i++) begin
            press(VEC[i][5:4], 3 + (i % 4));
            chk(tag_name(VEC[i][2:0]), unlock, VEC[i][3]);
        end
        // detector now in ST_0110

        // R4 + R5: long hold of 1 from ST_0110 must be one digit (to ST_01)
        press(2'd1, 40);
        chk("R9 drop on next digit", unlock, 1'b0);
        press(2'd1, 3);
        press(2'd0, 3);
        chk("R5 held press counted once", unlock, 1'b1);

        // R8 latency and R9 hold-through: get to ST_011, then time the final 0
        press(2'd0, 3);
        press(2'd1, 3);
        press(2'd1, 3);
        @(negedge clk);
        key0_raw = 1'b1;
        @(negedge clk);
        chk("R8 no change after 1 edge", unlock, 1'b0);
        @(negedge clk);
        chk("R8 no change after 2 edges", unlock, 1'b0);
        @(negedge clk);
        chk("R8 unlock on 3rd edge", unlock, 1'b1);
        repeat (10) @(negedge clk);
        chk("R9 unlock held during press", unlock, 1'b1);
        key0_raw = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 unlock after release", unlock, 1'b1);

        // R7: key0 held, key1 added and ignored, from ST_0110
        @(negedge clk);
        key0_raw = 1'b1;
        repeat (4) @(negedge clk);
        key1_raw = 1'b1;
        repeat (6) @(negedge clk);
        key0_raw = 1'b0;
        repeat (4) @(negedge clk);
        key1_raw = 1'b0;
        repeat (4) @(negedge clk);
        chk("R7 first digit taken", unlock, 1'b0);
        press(2'd1, 3);
        press(2'd1, 3);
        press(2'd0, 3);
        chk("R7 second key ignored", unlock, 1'b1);

        // R6: both pressed, key0 released first, key1 still held
        @(negedge clk);
        key0_raw = 1'b1;
        key1_raw = 1'b1;
        repeat (5) @(negedge clk);
        key0_raw = 1'b0;
        repeat (10) @(negedge clk);
        key1_raw = 1'b0;
        repeat (4) @(negedge clk);
        chk("R6 both then single release ignored", unlock, 1'b1);

        // R1: reset in the middle of a code (ST_011), then a 0
        press(2'd0, 3);
        press(2'd1, 3);
        press(2'd1, 3);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 reset clears unlock", unlock, 1'b0);
        rst = 1'b0;
        press(2'd0, 3);
        chk("R1 reset returns to idle", unlock, 1'b0);
        press(2'd1, 3);
        press(2'd1, 3);
        press(2'd0, 3);
        chk("R2 code after reset", unlock, 1'b1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule